// File: doc/BRIEF.md
# Memory Range Decoder Target Lookup

This block holds a bank of programmable memory range decoders. Each decoder has a 256 MiB aligned base and size, a control word and a list of eight byte-wide target port numbers. Given a host address, the block finds the interleaved target port to which an access at that address must be routed. Software-side logic programs the decoders through a simple 32-bit register write port. A lookup is started with a one-cycle request.

A lookup scans the active decoders in index order, one decoder per clock. The number of active decoders comes from an encoded count register. The scan stops at the first decoder whose range holds the address. If that decoder is committed and its interleave setting is legal, its address bits select one of its eight target bytes, and that byte is returned as the port number. If that first matching decoder is uncommitted, the lookup reports a miss, even when a later decoder would also match. A finished lookup raises a one-cycle done pulse, and the found flag and port number are held until the next completion.

Top module: `hdm_route_lookup`

## Requirements
- R1: After reset, busy, done, found and port are all zero. Every decoder is cleared (size 0, uncommitted), so a lookup on an unprogrammed bank misses.
- R2: Register select 7 holds the decoder count code in bits [3:0], and the decoder field of that write is ignored. Codes 0,1,2,3,4,5 give 1,2,4,6,8,10 active decoders, capped at the parameter NUM_DEC. Any other code gives zero active decoders. Decoders at or above the active count never match.
- R3: Per decoder, select 0 is the base low word, 1 the base high word, 2 the size low word and 3 the size high word. Only bits [31:28] of a low word are kept. Base and size are {high, low[31:28], 28'b0}.
- R4: A decoder matches when base <= address < base + size, computed without overflow. The lowest-indexed matching active decoder decides the result.
- R5: If the deciding decoder has its committed bit (control bit 8, select 4) clear, the result is a miss, even when a later decoder matches and is committed.
- R6: Control bits [3:0] are the granularity code g and bits [7:4] the ways code w. The interleave index is (address / (256 << g)) mod 2^w.
- R7: Index 0..3 selects byte (index*8) of the low target word (select 5). Index 4..7 selects byte ((index-4)*8) of the high target word (select 6). The selected byte is the port number.
- R8: A deciding decoder that is committed but has a ways code above 3 gives a miss.
- R9: A request is taken only when busy is low, and busy is high from the next cycle. Done pulses for one cycle, k+1 cycles after the request edge. k is the index of the deciding decoder, or the last active index when nothing matches, or 0 when no decoder is active. Busy is low while done is high. Found and port change only with done, and a miss reports port 0.
- R10: A request raised while busy is ignored, and the scan in progress completes with its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_dec | input | $clog2(NUM_DEC) | Decoder index of the write |
| wr_sel | input | 3 | Register select within the decoder (7 = count code) |
| wr_data | input | 32 | Write data |
| req_i | input | 1 | Lookup request |
| req_addr | input | 64 | Host address to look up |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |
| found_o | output | 1 | Last lookup hit a committed decoder |
| port_o | output | 8 | Port number of the last lookup (0 on miss) |

## Verification
The bench aims at range edges: the last byte inside a window and the first byte past it. A design that compared the end inclusively, or kept the low-word bits below 28, would return a hit where a miss is due. It checks that an uncommitted first match does not fall through to a later committed decoder, and that the first of two overlapping committed decoders wins; a priority or fall-through error changes the port number. It also runs large interleave indices that reach the high target word, a ways code above 3, and count codes that shrink or empty the active set. The done cycle is compared on every clock, so a scan that stops one decoder late or early shows up as a shift in timing.

// File: rtl/hdm_pkg.sv
package hdm_pkg;
    localparam int ADDR_W = 64;

    typedef enum logic [2:0] {
        SEL_BASE_LO = 3'd0,
        SEL_BASE_HI = 3'd1,
        SEL_SIZE_LO = 3'd2,
        SEL_SIZE_HI = 3'd3,
        SEL_CTRL    = 3'd4,
        SEL_LIST_LO = 3'd5,
        SEL_LIST_HI = 3'd6,
        SEL_COUNT   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [31:0] base_hi;
        logic [3:0]  base_lo;
        logic [31:0] size_hi;
        logic [3:0]  size_lo;
        logic        commit;
        logic [3:0]  ways;
        logic [3:0]  gran;
        logic [31:0] list_hi;
        logic [31:0] list_lo;
    } dec_regs_t;

    // encoded count code -> number of decoders
    function automatic logic [4:0] count_decode(input logic [3:0] code);
        case (code)
            4'd0: count_decode = 5'd1;
            4'd1: count_decode = 5'd2;
            4'd2: count_decode = 5'd4;
            4'd3: count_decode = 5'd6;
            4'd4: count_decode = 5'd8;
            4'd5: count_decode = 5'd10;
            default: count_decode = 5'd0;
        endcase
    endfunction
endpackage

// File: rtl/hdm_dec_regs.sv
module hdm_dec_regs
    import hdm_pkg::*;
#(
    parameter int NUM_DEC = 10,
    parameter int IDX_W   = $clog2(NUM_DEC)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_dec,
    input  logic [2:0]                    wr_sel,
    input  logic [31:0]                   wr_data,
    output dec_regs_t [NUM_DEC-1:0]       regs_o,
    output logic [3:0]                    cnt_code_o
);
    logic [3:0] code_d, code_q;

    always_comb begin
        code_d = code_q;
        if (wr_en && wr_sel == SEL_COUNT) code_d = wr_data[3:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
    end

    assign cnt_code_o = code_q;

    for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
        dec_regs_t r_d, r_q;
        logic      hit_w;

        assign hit_w = wr_en && (int'(wr_dec) == i);

        always_comb begin
            r_d = r_q;
            if (hit_w) begin
                case (reg_sel_e'(wr_sel))
                    SEL_BASE_LO: r_d.base_lo = wr_data[31:28];
                    SEL_BASE_HI: r_d.base_hi = wr_data;
                    SEL_SIZE_LO: r_d.size_lo = wr_data[31:28];
                    SEL_SIZE_HI: r_d.size_hi = wr_data;
                    SEL_CTRL: begin
                        r_d.gran   = wr_data[3:0];
                        r_d.ways   = wr_data[7:4];
                        r_d.commit = wr_data[8];
                    end
                    SEL_LIST_LO: r_d.list_lo = wr_data;
                    SEL_LIST_HI: r_d.list_hi = wr_data;
                    default: ;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) r_q <= '0;
            else        r_q <= r_d;
        end

        assign regs_o[i] = r_q;
    end
endmodule

// File: rtl/hdm_dec_eval.sv
module hdm_dec_eval
    import hdm_pkg::*;
(
    input  dec_regs_t          regs_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic               in_range_o,
    output logic               usable_o,
    output logic [7:0]         port_o
);
    logic [ADDR_W-1:0] base_w, size_w, shifted_w;
    logic [ADDR_W:0]   end_w;
    logic [3:0]        mask_w;
    logic [2:0]        idx_w;
    logic [31:0]       word_w;

    always_comb begin
        base_w     = {regs_i.base_hi, regs_i.base_lo, 28'b0};
        size_w     = {regs_i.size_hi, regs_i.size_lo, 28'b0};
        end_w      = {1'b0, base_w} + {1'b0, size_w};
        in_range_o = (addr_i >= base_w) && ({1'b0, addr_i} < end_w);
        usable_o   = regs_i.commit && (regs_i.ways <= 4'd3);
        shifted_w  = addr_i >> (5'd8 + {1'b0, regs_i.gran});
        mask_w     = (4'd1 << regs_i.ways[1:0]) - 4'd1;
        idx_w      = shifted_w[2:0] & mask_w[2:0];
        word_w     = idx_w[2] ? regs_i.list_hi : regs_i.list_lo;
        port_o     = word_w[{idx_w[1:0], 3'b000} +: 8];
    end
endmodule

// File: rtl/hdm_route_lookup.sv
module hdm_route_lookup
    import hdm_pkg::*;
#(
    parameter int NUM_DEC = 10,
    localparam int IDX_W  = $clog2(NUM_DEC),
    localparam int CNT_W  = $clog2(NUM_DEC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_dec,
    input  logic [2:0]         wr_sel,
    input  logic [31:0]        wr_data,
    input  logic               req_i,
    input  logic [63:0]        req_addr,
    output logic               busy_o,
    output logic               done_o,
    output logic               found_o,
    output logic [7:0]         port_o
);
    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic [CNT_W-1:0]  cnt;
        logic [63:0]       addr;
        logic              done;
        logic              found;
        logic [7:0]        port;
    } scan_t;

    scan_t s_d, s_q;

    dec_regs_t [NUM_DEC-1:0] regs_w;
    logic [3:0]              code_w;
    dec_regs_t               cur_w;
    logic                    in_range_w, usable_w;
    logic [7:0]              ev_port_w;
    logic [4:0]              raw_cnt_w;
    logic [CNT_W-1:0]        lim_cnt_w;
    logic [CNT_W:0]          nxt_w;
    logic                    active_w, last_w;

    hdm_dec_regs #(.NUM_DEC(NUM_DEC), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dec(wr_dec),
        .wr_sel(wr_sel), .wr_data(wr_data), .regs_o(regs_w),
        .cnt_code_o(code_w)
    );

    assign cur_w = (int'(s_q.idx) < NUM_DEC) ? regs_w[s_q.idx] : '0;

    hdm_dec_eval u_eval (
        .regs_i(cur_w), .addr_i(s_q.addr), .in_range_o(in_range_w),
        .usable_o(usable_w), .port_o(ev_port_w)
    );

    always_comb begin
        raw_cnt_w = count_decode(code_w);
        lim_cnt_w = (int'(raw_cnt_w) > NUM_DEC) ? CNT_W'(NUM_DEC) : CNT_W'(raw_cnt_w);
        nxt_w     = (CNT_W+1)'(s_q.idx) + 1'b1;
        active_w  = (CNT_W+1)'(s_q.idx) < {1'b0, s_q.cnt};
        last_w    = nxt_w >= {1'b0, s_q.cnt};

        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (req_i) begin
                s_d.busy = 1'b1;
                s_d.idx  = '0;
                s_d.cnt  = lim_cnt_w;
                s_d.addr = req_addr;
            end
        end else if (active_w && in_range_w) begin
            s_d.busy  = 1'b0;
            s_d.done  = 1'b1;
            s_d.found = usable_w;
            s_d.port  = usable_w ? ev_port_w : 8'd0;
        end else if (last_w) begin
            s_d.busy  = 1'b0;
            s_d.done  = 1'b1;
            s_d.found = 1'b0;
            s_d.port  = 8'd0;
        end else begin
            s_d.idx = s_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o  = s_q.busy;
    assign done_o  = s_q.done;
    assign found_o = s_q.found;
    assign port_o  = s_q.port;
endmodule

// File: rtl/hdm_route_chk.sv
module hdm_route_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       found_o,
    input logic [7:0] port_o
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(req_i));
    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(found_o) && $stable(port_o)));
    // R9
    miss_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !found_o) |-> (port_o == 8'd0));
    // R10
    scan_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o));
endmodule

bind hdm_route_lookup hdm_route_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .busy_o(busy_o),
    .done_o(done_o), .found_o(found_o), .port_o(port_o)
);

// File: tb/sim_hdm_route_lookup.sv
module sim_hdm_route_lookup;
    localparam int ND = 10;
    localparam time CLK = 20ns;

    logic        clk = 0, rst_n = 0;
    logic        wr_en = 0;
    logic [3:0]  wr_dec = 0;
    logic [2:0]  wr_sel = 0;
    logic [31:0] wr_data = 0;
    logic        req_i = 0;
    logic [63:0] req_addr = 0;
    logic        busy_o, done_o, found_o;
    logic [7:0]  port_o;

    int tests = 0, fails = 0;
    string cur_tag = "R1";

    hdm_route_lookup #(.NUM_DEC(ND)) u0 (.*);

    always #(CLK/2) clk = ~clk;

    // reference state
    logic [31:0] mbl[ND], mbh[ND], msl[ND], msh[ND], mct[ND], mll[ND], mlh[ND];
    int  mcode;
    bit  m_busy, m_done, m_found, p_found;
    logic [7:0] m_port, p_port;
    int  m_cnt;

    function automatic int active_count(int code);
        int n;
        case (code)
            0: n = 1; 1: n = 2; 2: n = 4; 3: n = 6; 4: n = 8; 5: n = 10;
            default: n = 0;
        endcase
        return (n > ND) ? ND : n;
    endfunction

    task automatic ref_lookup(input logic [63:0] a, output bit f,
                              output logic [7:0] p, output int k);
        int n = active_count(mcode);
        f = 0; p = 0; k = (n == 0) ? 0 : n - 1;
        for (int i = 0; i < n; i++) begin
            logic [64:0] b  = {1'b0, mbh[i], mbl[i] & 32'hF000_0000};
            logic [64:0] sz = {1'b0, msh[i], msl[i] & 32'hF000_0000};
            if ({1'b0, a} >= b && {1'b0, a} < b + sz) begin
                int g = int'(mct[i][3:0]);
                int w = int'(mct[i][7:4]);
                k = i;
                if (mct[i][8] && w <= 3) begin
                    logic [63:0] gsz = 64'd256 * (64'd1 << g);
                    logic [63:0] ix = (a / gsz) % (64'd1 << w);
                    f = 1;
                    if (ix < 4) p = mll[i] >> (8 * ix);
                    else        p = mlh[i] >> (8 * (ix - 4));
                end
                return;
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ND; i++) begin
                mbl[i] = 0; mbh[i] = 0; msl[i] = 0; msh[i] = 0;
                mct[i] = 0; mll[i] = 0; mlh[i] = 0;
            end
            mcode = 0; m_busy = 0; m_done = 0; m_found = 0; m_port = 0; m_cnt = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1; m_found = p_found; m_port = p_port;
                end
            end else if (req_i) begin
                int k;
                ref_lookup(req_addr, p_found, p_port, k);
                m_busy = 1; m_cnt = k + 1;
            end
            if (wr_en) begin
                if (wr_sel == 3'd7) mcode = int'(wr_data[3:0]);
                else if (wr_dec < ND) begin
                    case (wr_sel)
                        3'd0: mbl[wr_dec] = wr_data;
                        3'd1: mbh[wr_dec] = wr_data;
                        3'd2: msl[wr_dec] = wr_data;
                        3'd3: msh[wr_dec] = wr_data;
                        3'd4: mct[wr_dec] = wr_data;
                        3'd5: mll[wr_dec] = wr_data;
                        default: mlh[wr_dec] = wr_data;
                    endcase
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // cycle compare against the reference
    always @(negedge clk) if (rst_n) begin
        chk(busy_o === m_busy, "R9", "busy", 64'(busy_o), 64'(m_busy));
        chk(done_o === m_done, "R9", "done", 64'(done_o), 64'(m_done));
        chk(found_o === m_found, cur_tag, "found", 64'(found_o), 64'(m_found));
        chk(port_o === m_port, cur_tag, "port", 64'(port_o), 64'(m_port));
    end

    task automatic wr(input int d, input int s, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1; wr_dec = 4'(d); wr_sel = 3'(s); wr_data = v;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic look(input logic [63:0] a, input string tag);
        cur_tag = tag;
        @(negedge clk);
        req_i = 1; req_addr = a;
        @(negedge clk);
        req_i = 0;
        repeat (13) @(negedge clk);
    endtask

    localparam logic [63:0] B3 = 64'h1_0000_0000;
    localparam logic [63:0] SZ = 64'h1000_0000;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(busy_o === 0 && done_o === 0, "R1", "busy/done after reset",
            {busy_o, done_o}, 0);
        chk(found_o === 0 && port_o === 0, "R1", "found/port after reset",
            {found_o, port_o}, 0);
        look(64'h0, "R1");
        look(B3, "R1");

        wr(0, 7, 32'd5);                       // R2 ten decoders
        wr(3, 0, 32'h0FFF_FFFF);               // R3 low junk dropped
        wr(3, 1, 32'h1);
        wr(3, 2, 32'h1ABC_DEF0);               // R3 size 256 MiB
        wr(3, 3, 32'h0);
        wr(3, 4, 32'h0000_0120);               // commit, w=2, g=0
        wr(3, 5, 32'h4433_2211);
        wr(3, 6, 32'h8877_6655);
        look(B3, "R3");
        look(B3 + 64'h100, "R6");
        look(B3 + 64'h300, "R6");
        look(B3 + 64'h400, "R6");
        look(B3 - 1, "R4");
        look(B3 + SZ - 1, "R4");
        look(B3 + SZ, "R4");

        wr(3, 4, 32'h0000_0132);               // w=3, g=2 (1 KiB)
        look(B3 + 64'd5 * 1024, "R7");
        look(B3 + 64'd7 * 1024, "R7");
        look(B3 + 64'd3 * 1024, "R7");
        look(B3 + 64'd12 * 1024, "R7");

        wr(1, 0, 32'h0);                       // overlapping earlier decoder
        wr(1, 1, 32'h1);
        wr(1, 2, 32'h2000_0000);
        wr(1, 4, 32'h0000_0100);               // commit, w=0
        wr(1, 5, 32'h0000_00A7);
        look(B3 + 64'd5 * 1024, "R4");
        wr(1, 4, 32'h0000_0000);               // uncommitted first match
        look(B3 + 64'd5 * 1024, "R5");
        look(B3 + SZ + 64'h10, "R5");
        wr(1, 2, 32'h0);

        wr(3, 4, 32'h0000_0140);               // ways code 4
        look(B3, "R8");
        wr(3, 4, 32'h0000_01F0);
        look(B3, "R8");
        wr(3, 4, 32'h0000_0110);               // w=1 restored

        wr(5, 1, 32'h2);                       // decoder 5 at 8 GiB
        wr(5, 2, 32'h3000_0000);
        wr(5, 4, 32'h0000_0100);
        wr(5, 5, 32'h0000_005C);
        look(64'h2_0000_0040, "R2");
        wr(9, 7, 32'd2);                       // four decoders, index ignored
        look(64'h2_0000_0040, "R2");
        look(B3 + 64'h100, "R2");
        wr(0, 7, 32'd7);                       // zero decoders
        look(B3, "R2");
        wr(0, 7, 32'd0);                       // one decoder
        look(B3, "R2");
        wr(0, 7, 32'd5);

        // R10 request while busy ignored
        cur_tag = "R10";
        @(negedge clk);
        req_i = 1; req_addr = 64'h2_0000_0000;
        @(negedge clk);
        req_addr = B3 + 64'h100;
        @(negedge clk);
        req_i = 0;
        repeat (13) @(negedge clk);
        look(B3 + 64'h100, "R10");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK * 200000);
        fails++;
        tests++;
        $display("FAIL R9 watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule